// File: doc/BRIEF.md
# Glitch-Free Output Clock Stop Controller

This block decides, cycle by cycle, which generated output clocks may toggle. It gates three groups of outputs: a processor group that runs on the internal processor clock, an auxiliary group on a second clock, and a reference group on a slow reference clock. Two asynchronous active-low requests drive it. A stop request halts only the processor group. A power-down request parks every output and then turns off the VCO and the oscillator, in that order.

Every gate enable lives in a register that is updated on the falling edge of the clock it gates, so an output can only start or stop while its source is low. Stopped outputs therefore rest low, and no high phase is ever cut short. A restarted processor clock is held running for a minimum number of cycles before a new stop can take effect. Each output also has its own software enable bit. A global tristate bit removes the drive enable from every output.

Top module: `ckstop_ctrl`

## Requirements
- R1: While `rst_n` is low every `clk_out` bit is low and does not toggle, and `vco_en` and `osc_en` are both 1.
- R2: After `stop_n` falls, the last rising edge on the processor outputs (bits 0 to N_CPU-1) comes less than 4 processor cycles after the request. The auxiliary and reference outputs keep toggling while the stop is held.
- R3: Stopped processor outputs rest at 0. The first high phase after a restart lasts a full half period of `clk_cpu`.
- R4: After `stop_n` rises, the first rising edge on the processor outputs comes less than 4 processor cycles after the release.
- R5: Once the processor outputs restart, they deliver exactly MIN_RUN rising edges before a stop that is already pending takes effect.
- R6: After `pdn_n` falls, the processor outputs give their last rising edge less than 4 processor cycles later. While power-down is in effect, every output stays at 0.
- R7: `vco_en` falls no earlier than PARK_CYCLES processor cycles after the power-down request, and only after the last rising edge of every output. `osc_en` falls exactly one processor cycle after `vco_en`.
- R8: While power-down is in effect, `stop_n` has no effect on any output or on `vco_en`/`osc_en`. A stop request that is still held when power-down ends keeps the processor outputs stopped, while the other groups resume.
- R9: After `pdn_n` rises, `vco_en` returns less than 4 cycles later. The first processor edge comes at least LOCK_CYCLES cycles after `vco_en` returns, and less than LOCK_CYCLES+4 cycles after the release.
- R10: An output whose `cfg_en` bit is 0 stays low and gives no rising edge. The other outputs keep running.
- R11: `clk_oe` is all zeros while `cfg_tristate` is 1 and all ones while it is 0.
- R12: Output bits 0..N_CPU-1 follow `clk_cpu`, the next N_AUX bits follow `clk_aux`, and the top N_REF bits follow `clk_ref`, each at its source rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Internal processor clock; also clocks the sequencer |
| clk_aux | input | 1 | Source clock of the auxiliary group |
| clk_ref | input | 1 | Source clock of the reference group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low processor-group stop request |
| pdn_n | input | 1 | Asynchronous active-low power-down request |
| cfg_en | input | N_CPU+N_AUX+N_REF | Per-output software enable, 1 lets the output run |
| cfg_tristate | input | 1 | 1 withdraws the drive enable of every output |
| clk_out | output | N_CPU+N_AUX+N_REF | Gated output clocks |
| clk_oe | output | N_CPU+N_AUX+N_REF | Drive enable per output, 0 means high impedance |
| vco_en | output | 1 | VCO run enable |
| osc_en | output | 1 | Crystal oscillator run enable |

## Verification
The bench builds the block with two processor outputs, two auxiliary outputs and one reference output, two synchronizer stages, MIN_RUN of 8, PARK_CYCLES of 16 and LOCK_CYCLES of 10. The auxiliary clock runs at 1.5 times the processor period and the reference clock at twice that period. With these short counts, the bench can sweep the stop request over several phase offsets within a processor cycle, and can run a whole minimum-run window and two full power-down and wake sequences in a few thousand cycles. The small output count also lets it clear each `cfg_en` bit in turn, covering every output.

// File: rtl/ckstop_pkg.sv
`timescale 1ns/1ps
package ckstop_pkg;

   typedef enum logic [2:0] {
      PS_RUN     = 3'd0,
      PS_PARK    = 3'd1,
      PS_VCO_OFF = 3'd2,
      PS_OFF     = 3'd3,
      PS_WAKE    = 3'd4
   } pwr_state_e;

   // bits needed to hold values 0 .. n-1
   function automatic int unsigned ctr_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ckstop_sync.sv
`timescale 1ns/1ps
module ckstop_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= {STAGES{RST_VAL}};
      end else begin
         sr[0] <= d;
         for (int k = 1; k < STAGES; k++) sr[k] <= sr[k-1];
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/ckstop_gate.sv
`timescale 1ns/1ps
module ckstop_gate #(
   parameter int unsigned SYNC_STAGES = 0  // 0: req already in src_clk domain
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic req,
   output logic en,
   output logic clk_o
);
   logic req_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign req_s = req;
   end else begin : g_cross
      ckstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
         .clk   (src_clk),
         .rst_n (rst_n),
         .d     (req),
         .q     (req_s)
      );
   end

   // enable moves only while src_clk is low: no runt, full high phases
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en <= 1'b0;
      else        en <= req_s;
   end

   assign clk_o = src_clk & en;
endmodule

// File: rtl/ckstop_seq.sv
`timescale 1ns/1ps
module ckstop_seq
   import ckstop_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_RUN     = 100,
   parameter int unsigned PARK_CYCLES = 32,
   parameter int unsigned LOCK_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_n,
   input  logic pdn_n,
   output logic cpu_req,
   output logic slow_req,
   output logic cpu_run,
   output logic pd_hold,
   output logic vco_en,
   output logic osc_en
);
   localparam int unsigned RUN_W = ctr_w(MIN_RUN);
   localparam int unsigned CNT_W = ctr_w(max2(PARK_CYCLES, LOCK_CYCLES));
   localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(MIN_RUN - 1);
   localparam logic [CNT_W-1:0] PARK_LAST = CNT_W'(PARK_CYCLES - 1);
   localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);

   logic             stop_s, pdn_s, pd_req, hold, cpu_run_q;
   logic [RUN_W-1:0] run_cnt;
   logic [CNT_W-1:0] cnt;
   pwr_state_e       state;

   ckstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
      .clk(clk), .rst_n(rst_n), .d(stop_n), .q(stop_s)
   );
   ckstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pdn_sync (
      .clk(clk), .rst_n(rst_n), .d(pdn_n), .q(pdn_s)
   );

   assign pd_req   = ~pdn_s;
   assign pd_hold  = (state != PS_RUN) | pd_req;
   assign hold     = cpu_run_q & (run_cnt != RUN_LAST);
   assign cpu_req  = ~pd_hold & (stop_s | hold);
   assign slow_req = ~pd_hold;
   assign cpu_run  = cpu_run_q;
   assign vco_en   = (state != PS_VCO_OFF) && (state != PS_OFF);
   assign osc_en   = (state != PS_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_run_q <= 1'b0;
         run_cnt   <= '0;
      end else begin
         cpu_run_q <= cpu_req;
         if (!cpu_run_q)            run_cnt <= '0;
         else if (run_cnt != RUN_LAST) run_cnt <= run_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_RUN;
         cnt   <= '0;
      end else begin
         unique case (state)
            PS_RUN:     if (pd_req) begin state <= PS_PARK; cnt <= '0; end
            PS_PARK:    if (cnt == PARK_LAST) state <= PS_VCO_OFF;
                        else cnt <= cnt + 1'b1;
            PS_VCO_OFF: state <= PS_OFF;
            PS_OFF:     if (!pd_req) begin state <= PS_WAKE; cnt <= '0; end
            PS_WAKE:    if (cnt == LOCK_LAST) state <= PS_RUN;
                        else cnt <= cnt + 1'b1;
            default:    state <= PS_RUN;
         endcase
      end
   end
endmodule

// File: rtl/ckstop_ctrl.sv
`timescale 1ns/1ps
module ckstop_ctrl #(
   parameter int unsigned N_CPU       = 2,
   parameter int unsigned N_AUX       = 4,
   parameter int unsigned N_REF       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_RUN     = 100,
   parameter int unsigned PARK_CYCLES = 32,
   parameter int unsigned LOCK_CYCLES = 4096,
   localparam int unsigned N_OUT      = N_CPU + N_AUX + N_REF
) (
   input  logic             clk_cpu,
   input  logic             clk_aux,
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             stop_n,
   input  logic             pdn_n,
   input  logic [N_OUT-1:0] cfg_en,
   input  logic             cfg_tristate,
   output logic [N_OUT-1:0] clk_out,
   output logic [N_OUT-1:0] clk_oe,
   output logic             vco_en,
   output logic             osc_en
);
   localparam int unsigned N_SLOW = N_AUX + N_REF;

   if (N_CPU < 1 || N_AUX < 1 || N_REF < 1) begin : g_bad_groups
      $error("ckstop_ctrl: every group needs at least one output");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ckstop_ctrl: SYNC_STAGES must be at least 2");
   end
   if (MIN_RUN < 2 || PARK_CYCLES < 2 || LOCK_CYCLES < 2) begin : g_bad_counts
      $error("ckstop_ctrl: MIN_RUN, PARK_CYCLES and LOCK_CYCLES must be at least 2");
   end

   logic              cpu_req, slow_req, cpu_run, pd_hold;
   logic [N_SLOW-1:0] slow_req_q;
   logic [N_OUT-1:0]  gate_en;

   ckstop_seq #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_RUN     (MIN_RUN),
      .PARK_CYCLES (PARK_CYCLES),
      .LOCK_CYCLES (LOCK_CYCLES)
   ) u_seq (
      .clk      (clk_cpu),
      .rst_n    (rst_n),
      .stop_n   (stop_n),
      .pdn_n    (pdn_n),
      .cpu_req  (cpu_req),
      .slow_req (slow_req),
      .cpu_run  (cpu_run),
      .pd_hold  (pd_hold),
      .vco_en   (vco_en),
      .osc_en   (osc_en)
   );

   // requests bound for other domains leave the processor domain from a flop
   always_ff @(posedge clk_cpu or negedge rst_n) begin
      if (!rst_n) slow_req_q <= '0;
      else        slow_req_q <= {N_SLOW{slow_req}} & cfg_en[N_OUT-1:N_CPU];
   end

   for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
      if (gi < N_CPU) begin : g_cpu
         ckstop_gate #(.SYNC_STAGES(0)) u_gate (
            .src_clk (clk_cpu),
            .rst_n   (rst_n),
            .req     (cpu_req & cfg_en[gi]),
            .en      (gate_en[gi]),
            .clk_o   (clk_out[gi])
         );
      end else if (gi < N_CPU + N_AUX) begin : g_aux
         ckstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .src_clk (clk_aux),
            .rst_n   (rst_n),
            .req     (slow_req_q[gi-N_CPU]),
            .en      (gate_en[gi]),
            .clk_o   (clk_out[gi])
         );
      end else begin : g_ref
         ckstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .src_clk (clk_ref),
            .rst_n   (rst_n),
            .req     (slow_req_q[gi-N_CPU]),
            .en      (gate_en[gi]),
            .clk_o   (clk_out[gi])
         );
      end
   end

   assign clk_oe = {N_OUT{~cfg_tristate}};
endmodule

// File: rtl/ckstop_ctrl_chk.sv
`timescale 1ns/1ps
module ckstop_ctrl_chk #(
   parameter int unsigned N_OUT   = 8,
   parameter int unsigned MIN_RUN = 100
) (
   input logic             clk_cpu,
   input logic             rst_n,
   input logic [N_OUT-1:0] gate_en,
   input logic             cpu_run,
   input logic             pd_hold,
   input logic             vco_en,
   input logic             osc_en
);
   localparam int unsigned LEN_W = $clog2(MIN_RUN + 1);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MIN_RUN);

   logic [LEN_W-1:0] run_len;

   always_ff @(posedge clk_cpu or negedge rst_n) begin
      if (!rst_n)                run_len <= '0;
      else if (!cpu_run)         run_len <= '0;
      else if (run_len != LEN_MAX) run_len <= run_len + 1'b1;
   end

   AST_MIN_RUN_HELD: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      ($fell(cpu_run) && !$past(pd_hold)) |-> (run_len >= LEN_MAX)); // R5

   AST_VCO_OFF_PARKED: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      !vco_en |-> (gate_en == '0)); // R7

   AST_OSC_AFTER_VCO: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      !osc_en |-> !vco_en); // R7

   AST_VCO_FALL_IN_PD: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      $fell(vco_en) |-> pd_hold); // R6

   AST_OSC_BACK_FIRST: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      $rose(vco_en) |-> osc_en); // R9
endmodule

bind ckstop_ctrl ckstop_ctrl_chk #(.N_OUT(N_OUT), .MIN_RUN(MIN_RUN)) u_chk (
   .clk_cpu (clk_cpu),
   .rst_n   (rst_n),
   .gate_en (gate_en),
   .cpu_run (cpu_run),
   .pd_hold (pd_hold),
   .vco_en  (vco_en),
   .osc_en  (osc_en)
);

// File: tb/ckstop_ctrl_tb.sv
`timescale 1ns/1ps
module ckstop_ctrl_tb;
   localparam int NC = 2, NA = 2, NR = 1, NO = NC + NA + NR;
   localparam int MINR = 8, PARK = 16, LOCK = 10, SS = 2;
   localparam real T = 20.0;

   logic clk_cpu = 1'b0, clk_aux = 1'b0, clk_ref = 1'b0;
   logic rst_n = 1'b0, stop_n = 1'b1, pdn_n = 1'b1, cfg_tristate = 1'b0;
   logic [NO-1:0] cfg_en = '1;
   logic [NO-1:0] clk_out, clk_oe;
   logic vco_en, osc_en;

   always #10 clk_cpu = ~clk_cpu;
   always #15 clk_aux = ~clk_aux;
   always #20 clk_ref = ~clk_ref;

   ckstop_ctrl #(
      .N_CPU(NC), .N_AUX(NA), .N_REF(NR), .SYNC_STAGES(SS),
      .MIN_RUN(MINR), .PARK_CYCLES(PARK), .LOCK_CYCLES(LOCK)
   ) u_dut (
      .clk_cpu(clk_cpu), .clk_aux(clk_aux), .clk_ref(clk_ref), .rst_n(rst_n),
      .stop_n(stop_n), .pdn_n(pdn_n), .cfg_en(cfg_en), .cfg_tristate(cfg_tristate),
      .clk_out(clk_out), .clk_oe(clk_oe), .vco_en(vco_en), .osc_en(osc_en)
   );

   int  total = 0, fails = 0;
   int  cnt [NO];
   real first_t [NO], last_t [NO], w_first [NO];
   real t_vco_fall = 0.0, t_osc_fall = 0.0, t_vco_rise = 0.0;

   for (genvar g = 0; g < NO; g++) begin : g_mon
      always @(posedge clk_out[g]) begin
         cnt[g] = cnt[g] + 1;
         if (cnt[g] == 1) first_t[g] = $realtime;
         last_t[g] = $realtime;
      end
      always @(negedge clk_out[g]) begin
         if (cnt[g] == 1 && w_first[g] < 0.0) w_first[g] = $realtime - first_t[g];
      end
   end

   always @(negedge vco_en) t_vco_fall = $realtime;
   always @(negedge osc_en) t_osc_fall = $realtime;
   always @(posedge vco_en) t_vco_rise = $realtime;

   task automatic clr();
      for (int i = 0; i < NO; i++) begin
         cnt[i] = 0; first_t[i] = 0.0; last_t[i] = 0.0; w_first[i] = -1.0;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input real act, input real exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0.1f expected=%0.1f", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk_cpu);
      #5;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      #2_000_000;
      total++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      real t_req, lastmax;
      clr();
      // R1: reset state
      cyc(4);
      chk(clk_out == '0, "R1", "outputs low in reset", real'(clk_out), 0.0);
      chk(cnt[0] + cnt[NC] + cnt[NO-1] == 0, "R1", "no edges in reset",
          real'(cnt[0] + cnt[NC] + cnt[NO-1]), 0.0);
      chk(vco_en && osc_en, "R1", "vco/osc enabled in reset", real'({vco_en, osc_en}), 3.0);
      rst_n = 1'b1;
      cyc(20);

      // R12: group rates over 60 processor cycles
      clr();
      cyc(60);
      for (int i = 0; i < NO; i++) begin
         int exp_n;
         exp_n = (i < NC) ? 60 : (i < NC + NA) ? 40 : 30;
         chk(cnt[i] >= exp_n - 1 && cnt[i] <= exp_n + 1, "R12", "edge count per window",
             real'(cnt[i]), real'(exp_n));
      end

      // R11: tristate
      cfg_tristate = 1'b1; #1;
      chk(clk_oe == '0, "R11", "oe off when tristate", real'(clk_oe), 0.0);
      cfg_tristate = 1'b0; #1;
      chk(clk_oe == '1, "R11", "oe on when normal", real'(clk_oe), real'((1 << NO) - 1));

      // R10: clear each enable bit in turn
      for (int i = 0; i < NO; i++) begin
         cfg_en = ~(NO'(1) << i);
         cyc(8);
         clr();
         cyc(30);
         chk(cnt[i] == 0, "R10", "disabled output silent", real'(cnt[i]), 0.0);
         for (int j = 0; j < NO; j++)
            if (j != i) chk(cnt[j] > 0, "R10", "enabled output running", real'(cnt[j]), 1.0);
         cfg_en = '1;
         cyc(8);
      end

      // R2/R3/R4: stop and restart at several phase offsets
      for (int k = 0; k < 4; k++) begin
         int off;
         off = 2 + 5 * k;
         cyc(MINR + 4);
         @(posedge clk_cpu); #(off);
         clr(); t_req = $realtime; stop_n = 1'b0;
         cyc(10);
         chk(cnt[0] > 0 && last_t[0] - t_req < 4.0 * T, "R2", "off latency",
             last_t[0] - t_req, 4.0 * T);
         clr();
         cyc(20);
         chk(cnt[0] == 0 && cnt[NC-1] == 0, "R3", "stopped outputs silent",
             real'(cnt[0] + cnt[NC-1]), 0.0);
         chk(clk_out[NC-1:0] == '0, "R3", "stopped outputs low", real'(clk_out[NC-1:0]), 0.0);
         chk(cnt[NC] > 0 && cnt[NO-1] > 0, "R2", "other groups keep running",
             real'(cnt[NO-1]), 1.0);
         @(posedge clk_cpu); #(off);
         clr(); t_req = $realtime; stop_n = 1'b1;
         cyc(10);
         chk(cnt[0] > 0 && first_t[0] - t_req < 4.0 * T, "R4", "on latency",
             first_t[0] - t_req, 4.0 * T);
         chk(w_first[0] > 9.99 && w_first[0] < 10.01, "R3", "first high phase width",
             w_first[0], T / 2.0);
      end

      // R5: minimum run with a stop pending during restart
      cyc(MINR + 4);
      stop_n = 1'b0;
      cyc(10);
      @(posedge clk_cpu); #7;
      clr(); stop_n = 1'b1;
      cyc(2);
      stop_n = 1'b0;
      cyc(MINR + 12);
      chk(cnt[0] == MINR, "R5", "edges before pending stop", real'(cnt[0]), real'(MINR));
      chk(cnt[1] == MINR, "R5", "edges before pending stop, second output",
          real'(cnt[1]), real'(MINR));
      stop_n = 1'b1;
      cyc(MINR + 4);

      // R6/R7: power-down ordering
      @(posedge clk_cpu); #7;
      clr(); t_req = $realtime; pdn_n = 1'b0;
      cyc(PARK + 12);
      chk(last_t[0] - t_req < 4.0 * T, "R6", "processor stop latency in power-down",
          last_t[0] - t_req, 4.0 * T);
      chk(!vco_en && !osc_en, "R7", "vco and osc off", real'({vco_en, osc_en}), 0.0);
      lastmax = 0.0;
      for (int i = 0; i < NO; i++) if (last_t[i] > lastmax) lastmax = last_t[i];
      chk(t_vco_fall > lastmax, "R7", "vco off after last output edge", t_vco_fall, lastmax);
      chk(t_vco_fall - t_req >= PARK * T, "R7", "park wait before vco off",
          t_vco_fall - t_req, PARK * T);
      chk(t_osc_fall - t_vco_fall > T - 0.01 && t_osc_fall - t_vco_fall < T + 0.01, "R7",
          "osc off one cycle after vco", t_osc_fall - t_vco_fall, T);

      // R8: stop toggling ignored in power-down
      clr();
      stop_n = 1'b0; cyc(5); stop_n = 1'b1; cyc(5); stop_n = 1'b0; cyc(10);
      chk(cnt[0] + cnt[NC] + cnt[NO-1] == 0, "R8", "no edges while powered down",
          real'(cnt[0] + cnt[NC] + cnt[NO-1]), 0.0);
      chk(clk_out == '0, "R6", "all outputs low in power-down", real'(clk_out), 0.0);
      chk(!vco_en && !osc_en, "R8", "stop does not wake vco/osc", real'({vco_en, osc_en}), 0.0);

      // R8/R9: wake with stop still held
      @(posedge clk_cpu); #7;
      clr(); t_req = $realtime; pdn_n = 1'b1;
      cyc(LOCK + 15);
      chk(t_vco_rise - t_req < 4.0 * T && vco_en && osc_en, "R9", "vco back latency",
          t_vco_rise - t_req, 4.0 * T);
      chk(cnt[0] == 0, "R8", "held stop keeps processor outputs off", real'(cnt[0]), 0.0);
      chk(cnt[NC] > 0 && cnt[NO-1] > 0, "R8", "other groups resume", real'(cnt[NC]), 1.0);
      clr(); stop_n = 1'b1;
      cyc(6);
      chk(cnt[0] > 0, "R4", "processor resumes after stop release", real'(cnt[0]), 1.0);

      // R9: wake timing with no stop pending
      cyc(MINR + 4);
      pdn_n = 1'b0;
      cyc(PARK + 12);
      @(posedge clk_cpu); #7;
      clr(); t_req = $realtime; pdn_n = 1'b1;
      cyc(LOCK + 12);
      chk(cnt[0] > 0 && first_t[0] - t_vco_rise >= LOCK * T, "R9", "lock wait after vco",
          first_t[0] - t_vco_rise, LOCK * T);
      chk(first_t[0] - t_req < (LOCK + 4) * T, "R9", "run latency after release",
          first_t[0] - t_req, (LOCK + 4) * T);

      summary();
      $finish;
   end
endmodule